// File: doc/BRIEF.md
# SPI Controller with Error Detection

This block is a byte-wide SPI controller that runs either as the clock-driving master or as a selected slave. Software sees three registers on a small synchronous bus: control, status and data. A write to the data register in master mode starts a transfer. The block shifts the byte out most significant bit first while it gathers the byte coming back. In slave mode the same write preloads the byte that the next transfer from the remote master clocks out. Clock polarity and phase can be selected, and in master mode the serial clock comes from a divider of the system clock.

Most of the logic goes to error handling. If a master's select input is pulled low, another master is contending for the bus. The block then drops to slave mode, disables itself and raises a mode-fault flag. A data write that arrives while a transfer owns the shift register is refused and flagged as a collision. In slave mode the rule for this depends on the phase setting. A byte that completes while the previous one is still unread is discarded and flagged as an overrun. Completion and mode-fault raise an interrupt request when interrupts are enabled.

Register map (bus_addr): 0 = control, 1 = status, 2 = data, 3 reads as zero. Control bits: [0] enable, [1] master, [2] clock polarity, [3] clock phase, [5:4] rate code, [6] interrupt enable. Status bits: [0] done, [1] collision, [2] mode fault, [3] overrun.

Top module: `spi_ctl_err`

## Requirements
- R1: After reset the control and status registers read 0, irq_o is 0 and sck_o is 0.
- R2: In master mode a data write shifts the byte out on mosi_o MSB first over 8 clock periods, captures 8 bits from miso_i, sets the done flag (status bit 0) and makes the captured byte readable at address 2.
- R3: Rate codes 0, 1, 2 and 3 give a serial clock half-period of 1, 2, 8 and 16 system clocks. The first edge comes one half-period after the data write is accepted.
- R4: The polarity bit (control bit 2) sets the idle level of sck_o. With the phase bit (control bit 3) at 0, data is sampled on the leading edge and changed on the trailing edge. With it at 1, data is changed on the leading edge and sampled on the trailing edge.
- R5: When master and enable are both set and ss_n_i is low (after a two-flop synchroniser), the block clears enable and master, sets the mode-fault flag (status bit 2) and stops any transfer with sck_o at idle.
- R6: A data write while a master transfer is running sets the collision flag (status bit 1). The running byte completes unchanged, and the written byte is discarded and starts no transfer.
- R7: In slave mode with phase 0, a data write while ss_n_i is low sets the collision flag and is discarded. The byte preloaded earlier is the one shifted out on miso_o.
- R8: In slave mode with phase 1, a data write while selected but before the first serial clock edge is accepted with no collision. A write between the first edge and the end of the eighth bit sets the collision flag and is discarded.
- R9: When a byte completes while the done flag is still set, the overrun flag (status bit 3) is set, the done flag stays set and the data register keeps the earlier byte.
- R10: Done, collision and overrun are cleared by a status read that finds done or collision set, followed by a data register read or write. A data access with no preceding status read leaves them set.
- R11: Mode fault is cleared by a status read that finds it set, followed by a control write. A control write with no preceding status read leaves it set.
- R12: irq_o is high exactly while the interrupt-enable bit is set and the done or mode-fault flag is set.
- R13: In slave mode the block samples mosi_i on sck_i edges chosen by polarity and phase, sets the done flag after 8 bits and makes the received byte readable, while driving its preloaded byte MSB first on miso_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, combinational from bus_addr |
| sck_o | output | 1 | Serial clock driven in master mode |
| mosi_o | output | 1 | Serial data out in master mode |
| miso_i | input | 1 | Serial data in for master mode |
| ss_n_i | input | 1 | Active-low select: picks the slave, or signals contention to a master |
| sck_i | input | 1 | Serial clock from a remote master |
| mosi_i | input | 1 | Serial data in for slave mode |
| miso_o | output | 1 | Serial data out in slave mode |
| irq_o | output | 1 | Interrupt request |

## Verification
A lost or extra baud tick, or a wrong edge count, shows at sck_o in the very cycle it happens, because the serial clock level is predicted and compared on every system clock of each master transfer. A mis-set done or mode-fault flag reaches irq_o in the next cycle, and irq_o is compared on every cycle as well. Wrong shift-register content shows up only at the end of the byte, as a mismatch in the bits collected from mosi_o or miso_o or in the data read back. Flag-clearing mistakes show up on the next status read.

// File: rtl/spi_err_pkg.sv
`timescale 1ns/1ps
package spi_err_pkg;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;

  localparam int RATE_CW = 5;

  // control word, LSB first: enable, master, polarity, phase, rate, irq enable
  typedef struct packed {
    logic       ie;
    logic [1:0] rate;
    logic       cpha;
    logic       cpol;
    logic       mstr;
    logic       ena;
  } ctrl_t;

  // serial clock half-period in system clocks for a rate code
  function automatic int unsigned half_period(input logic [1:0] rate);
    case (rate)
      2'd0:    return 1;
      2'd1:    return 2;
      2'd2:    return 8;
      default: return 16;
    endcase
  endfunction

endpackage

// File: rtl/spi_baud.sv
`timescale 1ns/1ps
module spi_baud
  import spi_err_pkg::*;
#(
  parameter int CW = RATE_CW
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] rate,
  output logic       tick
);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  assign lim  = CW'(half_period(rate) - 1);
  assign tick = run && (cnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end

  // R3: ticks are spaced one half-period apart
  p_tick_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && lim != '0 && $stable(rate)) |=> !tick);

endmodule

// File: rtl/spi_master_eng.sv
`timescale 1ns/1ps
module spi_master_eng #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          abort,
  input  logic [DW-1:0] din,
  input  logic          cpol,
  input  logic          cpha,
  input  logic          tick,
  input  logic          miso,
  output logic          busy,
  output logic          sck,
  output logic          mosi,
  output logic          done,
  output logic [DW-1:0] dout
);

  localparam int EW = $clog2(2 * DW);
  localparam logic [EW-1:0] LAST = EW'(2 * DW - 1);

  logic [DW-1:0] sreg;
  logic [EW-1:0] ec;
  logic          busy_q, act_q, rbit, mosi_q;
  logic          lead_edge, trail_edge;

  assign lead_edge  = busy_q & tick & ~ec[0];
  assign trail_edge = busy_q & tick &  ec[0];
  assign done       = trail_edge & (ec == LAST);
  assign dout       = {sreg[DW-2:0], cpha ? miso : rbit};
  assign busy       = busy_q;
  assign sck        = act_q ^ cpol;
  assign mosi       = mosi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      act_q  <= 1'b0;
      ec     <= '0;
      sreg   <= '0;
      rbit   <= 1'b0;
      mosi_q <= 1'b0;
    end else if (abort) begin
      busy_q <= 1'b0;
      act_q  <= 1'b0;
      ec     <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      act_q  <= 1'b0;
      ec     <= '0;
      sreg   <= din;
      mosi_q <= din[DW-1];
    end else if (busy_q && tick) begin
      act_q <= ~act_q;
      if (lead_edge) begin
        if (!cpha) rbit   <= miso;
        else       mosi_q <= sreg[DW-1];
      end else begin
        if (!cpha) begin
          sreg   <= {sreg[DW-2:0], rbit};
          mosi_q <= sreg[DW-2];
        end else begin
          sreg <= {sreg[DW-2:0], miso};
        end
      end
      if (ec == LAST) begin
        ec     <= '0;
        busy_q <= 1'b0;
      end else begin
        ec <= ec + 1'b1;
      end
    end
  end

  // R4: a new transfer begins with the clock at its idle level
  p_start_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !abort && !busy_q) |=> (busy && (sck == cpol || !$stable(cpol))));

  // R2: the last edge releases the engine
  p_done_frees_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !busy);

endmodule

// File: rtl/spi_slave_eng.sv
`timescale 1ns/1ps
module spi_slave_eng #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          cpol,
  input  logic          cpha,
  input  logic          ss_n,
  input  logic          sck_in,
  input  logic          mosi_in,
  input  logic          load,
  input  logic [DW-1:0] din,
  output logic          miso,
  output logic          done,
  output logic [DW-1:0] dout,
  output logic          in_window
);

  localparam int BW = $clog2(DW);
  localparam logic [BW-1:0] LASTB = BW'(DW - 1);

  logic          sck_m, sck_s, sck_p, mo_m, mo_s;
  logic [DW-1:0] sreg;
  logic [BW-1:0] bc;
  logic          rbit, miso_q, started_q;
  logic          act, lvl_now, lvl_old, lead, trail;

  assign act     = en & ~ss_n;
  assign lvl_now = sck_s ^ cpol;
  assign lvl_old = sck_p ^ cpol;
  assign lead    = act &  lvl_now & ~lvl_old;
  assign trail   = act & ~lvl_now &  lvl_old;

  assign done      = trail & (bc == LASTB);
  assign dout      = {sreg[DW-2:0], cpha ? mo_s : rbit};
  assign miso      = miso_q;
  assign in_window = started_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_m <= 1'b0; sck_s <= 1'b0; sck_p <= 1'b0;
      mo_m  <= 1'b0; mo_s  <= 1'b0;
    end else begin
      sck_m <= sck_in; sck_s <= sck_m; sck_p <= sck_s;
      mo_m  <= mosi_in; mo_s <= mo_m;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg      <= '0;
      bc        <= '0;
      rbit      <= 1'b0;
      miso_q    <= 1'b0;
      started_q <= 1'b0;
    end else begin
      if (load) sreg <= din;
      if (!act) begin
        bc        <= '0;
        started_q <= 1'b0;
        miso_q    <= load ? din[DW-1] : sreg[DW-1];
      end else begin
        if (lead) begin
          started_q <= 1'b1;
          if (!cpha) rbit   <= mo_s;
          else       miso_q <= sreg[DW-1];
        end
        if (trail) begin
          if (!cpha) begin
            sreg   <= {sreg[DW-2:0], rbit};
            miso_q <= sreg[DW-2];
          end else begin
            sreg <= {sreg[DW-2:0], mo_s};
          end
          if (bc == LASTB) begin
            bc        <= '0;
            started_q <= 1'b0;
          end else begin
            bc <= bc + 1'b1;
          end
        end
      end
    end
  end

  // R8: deselecting the slave closes the collision window
  p_window_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !act |=> !in_window);

endmodule

// File: rtl/spi_ctl_err.sv
`timescale 1ns/1ps
module spi_ctl_err
  import spi_err_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          sck_o,
  output logic          mosi_o,
  input  logic          miso_i,
  input  logic          ss_n_i,
  input  logic          sck_i,
  input  logic          mosi_i,
  output logic          miso_o,
  output logic          irq_o
);

  localparam int CTRL_W = $bits(ctrl_t);

  ctrl_t         ctrl_q;
  logic          spif_q, wcol_q, modf_q, ovr_q;
  logic          arm_x_q, arm_m_q;
  logic [DW-1:0] rxbuf_q;
  logic          ss_m, ss_s;

  // named internal events
  logic rd_stat, rd_data, wr_data, wr_ctrl, data_access;
  logic is_master, is_slave, mode_fault, collide;
  logic m_start, s_load, clr_x, clr_m, xfer_done;
  logic [DW-1:0] xfer_byte;

  logic          tick, m_busy, m_done, s_done, s_window;
  logic [DW-1:0] m_dout, s_dout;

  assign rd_stat     = bus_sel & ~bus_wr & (bus_addr == A_STAT);
  assign rd_data     = bus_sel & ~bus_wr & (bus_addr == A_DATA);
  assign wr_data     = bus_sel &  bus_wr & (bus_addr == A_DATA);
  assign wr_ctrl     = bus_sel &  bus_wr & (bus_addr == A_CTRL);
  assign data_access = rd_data | wr_data;

  assign is_master  = ctrl_q.ena &  ctrl_q.mstr;
  assign is_slave   = ctrl_q.ena & ~ctrl_q.mstr;
  assign mode_fault = is_master & ~ss_s;
  assign collide    = wr_data & ((is_master & m_busy) |
                                 (is_slave & (ctrl_q.cpha ? s_window : ~ss_s)));
  assign m_start    = wr_data & is_master & ~m_busy & ~mode_fault;
  assign s_load     = wr_data & ~is_master & ~collide;
  assign clr_x      = data_access & arm_x_q;
  assign clr_m      = wr_ctrl & arm_m_q;
  assign xfer_done  = m_done | s_done;
  assign xfer_byte  = m_done ? m_dout : s_dout;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ss_m <= 1'b1;
      ss_s <= 1'b1;
    end else begin
      ss_m <= ss_n_i;
      ss_s <= ss_m;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      spif_q  <= 1'b0;
      wcol_q  <= 1'b0;
      modf_q  <= 1'b0;
      ovr_q   <= 1'b0;
      arm_x_q <= 1'b0;
      arm_m_q <= 1'b0;
      rxbuf_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
      if (mode_fault) begin
        ctrl_q.ena  <= 1'b0;
        ctrl_q.mstr <= 1'b0;
      end

      if (rd_stat && (spif_q || wcol_q)) arm_x_q <= 1'b1;
      else if (data_access)              arm_x_q <= 1'b0;
      if (rd_stat && modf_q)             arm_m_q <= 1'b1;
      else if (wr_ctrl)                  arm_m_q <= 1'b0;

      if (clr_x) begin
        spif_q <= 1'b0;
        wcol_q <= 1'b0;
        ovr_q  <= 1'b0;
      end
      if (clr_m)      modf_q <= 1'b0;
      if (mode_fault) modf_q <= 1'b1;
      if (collide)    wcol_q <= 1'b1;
      if (xfer_done) begin
        spif_q <= 1'b1;
        if (spif_q) ovr_q   <= 1'b1;
        else        rxbuf_q <= xfer_byte;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL:  bus_rdata = DW'(ctrl_q);
      A_STAT:  bus_rdata = DW'({ovr_q, modf_q, wcol_q, spif_q});
      A_DATA:  bus_rdata = rxbuf_q;
      default: bus_rdata = '0;
    endcase
  end

  assign irq_o = ctrl_q.ie & (spif_q | modf_q);

  spi_baud #(.CW(RATE_CW)) u_baud (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (m_busy),
    .rate (ctrl_q.rate),
    .tick (tick)
  );

  spi_master_eng #(.DW(DW)) u_master (
    .clk  (clk),
    .rst_n(rst_n),
    .start(m_start),
    .abort(mode_fault),
    .din  (bus_wdata),
    .cpol (ctrl_q.cpol),
    .cpha (ctrl_q.cpha),
    .tick (tick),
    .miso (miso_i),
    .busy (m_busy),
    .sck  (sck_o),
    .mosi (mosi_o),
    .done (m_done),
    .dout (m_dout)
  );

  spi_slave_eng #(.DW(DW)) u_slave (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (is_slave),
    .cpol     (ctrl_q.cpol),
    .cpha     (ctrl_q.cpha),
    .ss_n     (ss_s),
    .sck_in   (sck_i),
    .mosi_in  (mosi_i),
    .load     (s_load),
    .din      (bus_wdata),
    .miso     (miso_o),
    .done     (s_done),
    .dout     (s_dout),
    .in_window(s_window)
  );

  // R5: contention drops the unit to a disabled slave and halts the engine
  p_modf_effect_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mode_fault |=> (!ctrl_q.ena && !ctrl_q.mstr && modf_q && !m_busy));

  // R6: a colliding write neither stops nor restarts the running byte
  p_wcol_keeps_xfer_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && m_busy && !m_done && !mode_fault) |=> (m_busy && wcol_q));

  // R9: an overrun leaves the unread byte in place
  p_ovr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && spif_q) |=> ($stable(rxbuf_q) && ovr_q && spif_q));

  // R10: a data access that was not armed clears nothing
  p_clear_needs_arm_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (data_access && !arm_x_q && spif_q) |=> spif_q);

  // R12: completion with interrupts enabled raises the request
  p_irq_on_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && ctrl_q.ie && !wr_ctrl) |=> irq_o);

endmodule

// File: tb/test_spi_ctl_err.sv
`timescale 1ns/1ps
module test_spi_ctl_err;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       sck_o, mosi_o, miso_o, irq_o;
  logic       miso_i = 1'b0, ss_n_i = 1'b1, sck_i = 1'b0, mosi_i = 1'b0;

  int checks = 0;
  int bad = 0;
  bit m_spif = 1'b0;   // reference model: done flag before a transfer

  always #2.5 clk = ~clk;

  spi_ctl_err #(.DW(8)) i_spi_ctl_err (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sck_o(sck_o), .mosi_o(mosi_o), .miso_i(miso_i),
    .ss_n_i(ss_n_i), .sck_i(sck_i), .mosi_i(mosi_i),
    .miso_o(miso_o), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic int halfp(input int rate);
    int h = 16;
    if (rate == 0) h = 1;
    else if (rate == 1) h = 2;
    else if (rate == 2) h = 8;
    return h;
  endfunction

  function automatic logic [7:0] mkctrl(input bit ie, input int rate, input bit cpha,
                                        input bit cpol, input bit mstr, input bit ena);
    logic [7:0] v = 8'h00;
    v[6] = ie; v[5:4] = rate[1:0]; v[3] = cpha; v[2] = cpol; v[1] = mstr; v[0] = ena;
    return v;
  endfunction

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bwr(input logic [1:0] a, input logic [7:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic brd(input logic [1:0] a, output logic [7:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic expect_reg(input string tag, input logic [1:0] a, input logic [7:0] exp);
    logic [7:0] v;
    brd(a, v);
    chk(tag, {24'h0, v}, {24'h0, exp});
  endtask

  // master transfer with a per-cycle reference of sck_o and irq_o
  task automatic m_xfer(input logic [7:0] tx, input logic [7:0] rx, input int rate,
                        input bit cp, input bit ph, input bit ie,
                        input int coll_j, input logic [7:0] coll_d);
    int h = halfp(rate);
    int prev = 0;
    bit mq[$];
    logic [7:0] got;
    miso_i = rx[7];
    bwr(2'd2, tx);
    for (int j = 0; j <= 16 * h + 2; j++) begin
      int edges = (j / h > 16) ? 16 : j / h;
      int b;
      chk("R3 R4 sck level", {31'h0, sck_o}, {31'h0, cp ^ edges[0]});
      chk("R12 irq", {31'h0, irq_o}, {31'h0, ie & (m_spif | (edges == 16))});
      if (edges > prev) begin
        int e = edges - 1;
        if (e[0] == ph) mq.push_back(mosi_o);
        prev = edges;
      end
      b = ph ? edges / 2 : (edges + 1) / 2;
      if (b > 7) b = 7;
      miso_i = rx[7 - b];
      if (j == coll_j) begin
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = coll_d;
      end else if (j == coll_j + 1) begin
        bus_sel = 1'b0; bus_wr = 1'b0;
      end
      @(negedge clk);
    end
    got = 8'h00;
    foreach (mq[k]) got = {got[6:0], mq[k]};
    chk("R2 R4 mosi bit count", mq.size(), 8);
    chk("R2 R6 mosi byte", {24'h0, got}, {24'h0, tx});
    m_spif = 1'b1;
  endtask

  // bench acts as remote master on sck_i / mosi_i, collects miso_o
  task automatic s_xfer(input logic [7:0] tx, input bit cp, input bit ph,
                        input int coll_i, output logic [7:0] got);
    localparam int HB = 6;
    got = 8'h00;
    for (int i = 0; i < 8; i++) begin
      if (!ph) begin
        mosi_i = tx[7 - i];
        wait_n(HB);
        got[7 - i] = miso_o;
        sck_i = ~cp;
        wait_n(HB);
        sck_i = cp;
      end else begin
        sck_i = ~cp;
        mosi_i = tx[7 - i];
        wait_n(HB);
        got[7 - i] = miso_o;
        if (i == coll_i) bwr(2'd2, 8'h00);
        sck_i = cp;
        wait_n(HB);
      end
    end
    wait_n(HB);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    logic [7:0] got;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);

    // R1 reset state
    chk("R1 irq", {31'h0, irq_o}, 32'h0);
    chk("R1 sck", {31'h0, sck_o}, 32'h0);
    expect_reg("R1 ctrl", 2'd0, 8'h00);
    expect_reg("R1 status", 2'd1, 8'h00);

    // R2 basic master byte, rate 0, mode 0
    bwr(2'd0, mkctrl(1, 0, 0, 0, 1, 1));
    m_xfer(8'hA5, 8'h3C, 0, 0, 0, 1, -10, 8'h00);
    expect_reg("R2 done flag", 2'd1, 8'h01);
    expect_reg("R2 rx byte", 2'd2, 8'h3C);
    expect_reg("R10 cleared after status+data", 2'd1, 8'h00);
    m_spif = 1'b0;

    // R6 collision during master transfer, rate 1, polarity 1, phase 1
    bwr(2'd0, mkctrl(1, 1, 1, 1, 1, 1));
    m_xfer(8'h96, 8'h5A, 1, 1, 1, 1, 5, 8'hFF);
    expect_reg("R6 done+collision", 2'd1, 8'h03);
    expect_reg("R6 rx byte unaffected", 2'd2, 8'h5A);
    expect_reg("R10 collision cleared", 2'd1, 8'h00);
    m_spif = 1'b0;

    // R9 overrun: rate 2 phase 1, then rate 3 polarity 1 without clearing
    bwr(2'd0, mkctrl(1, 2, 1, 0, 1, 1));
    m_xfer(8'h3C, 8'hC3, 2, 0, 1, 1, -10, 8'h00);
    bwr(2'd0, mkctrl(1, 3, 0, 1, 1, 1));
    m_xfer(8'h81, 8'h7E, 3, 1, 0, 1, -10, 8'h00);
    expect_reg("R9 overrun flag", 2'd1, 8'h09);
    expect_reg("R9 earlier byte kept", 2'd2, 8'hC3);
    expect_reg("R10 overrun cleared", 2'd1, 8'h00);
    m_spif = 1'b0;

    // R10 data access without status read leaves done set
    bwr(2'd0, mkctrl(1, 0, 0, 0, 1, 1));
    m_xfer(8'h11, 8'h22, 0, 0, 0, 1, -10, 8'h00);
    expect_reg("R10 unarmed data read", 2'd2, 8'h22);
    expect_reg("R10 done still set", 2'd1, 8'h01);
    expect_reg("R10 armed data read", 2'd2, 8'h22);
    expect_reg("R10 done cleared", 2'd1, 8'h00);
    m_spif = 1'b0;

    // R5 mode fault, R11 its clearing, R12 its interrupt
    ss_n_i = 1'b0;
    wait_n(4);
    expect_reg("R5 ena and master cleared", 2'd0, 8'h40);
    chk("R5 sck idle", {31'h0, sck_o}, 32'h0);
    chk("R12 irq on mode fault", {31'h0, irq_o}, 32'h1);
    bwr(2'd0, 8'h40);
    expect_reg("R11 unarmed ctrl write keeps fault", 2'd1, 8'h04);
    bwr(2'd0, 8'h40);
    expect_reg("R11 fault cleared", 2'd1, 8'h00);
    chk("R12 irq dropped", {31'h0, irq_o}, 32'h0);
    ss_n_i = 1'b1;
    wait_n(4);

    // R7 slave phase 0: preload, collision while selected, R13 receive
    bwr(2'd0, mkctrl(0, 0, 0, 0, 0, 1));
    sck_i = 1'b0;
    bwr(2'd2, 8'hB4);
    expect_reg("R7 preload accepted", 2'd1, 8'h00);
    ss_n_i = 1'b0;
    wait_n(4);
    bwr(2'd2, 8'hEE);
    s_xfer(8'h69, 0, 0, -1, got);
    chk("R7 preloaded byte shifted out", {24'h0, got}, 32'hB4);
    expect_reg("R7 collision and done", 2'd1, 8'h03);
    expect_reg("R13 slave rx byte", 2'd2, 8'h69);
    expect_reg("R10 slave flags cleared", 2'd1, 8'h00);
    ss_n_i = 1'b1;
    wait_n(4);

    // R8 slave phase 1, polarity 1: early write accepted, in-window write refused
    bwr(2'd0, mkctrl(0, 0, 1, 1, 0, 1));
    sck_i = 1'b1;
    wait_n(4);
    ss_n_i = 1'b0;
    wait_n(4);
    bwr(2'd2, 8'h5C);
    expect_reg("R8 write before first edge accepted", 2'd1, 8'h00);
    s_xfer(8'hA7, 1, 1, 3, got);
    chk("R8 R13 miso byte", {24'h0, got}, 32'h5C);
    expect_reg("R8 in-window collision", 2'd1, 8'h03);
    expect_reg("R13 slave rx byte phase 1", 2'd2, 8'hA7);
    ss_n_i = 1'b1;
    wait_n(4);

    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule